// File: doc/BRIEF.md
# Banked Nibble RAM Address Unit

This unit sits beside a 4-bit core and owns its data memory: 500 nibbles split into two banks. Bank 0 is populated at offsets 00h to F3h (244 nibbles); bank 1 is fully populated at offsets 00h to FFh (256 nibbles). The unit keeps a bank-select bit, two 4-bit pointer registers (high and low), and forms a 9-bit memory address from one of three modes: pointer pair, 8-bit direct operand, or a 4-bit zero-page operand that always lands in bank 0.

Each accepted request is a read, a write, or a single-bit set or clear. A read returns its nibble one cycle later. A bit operation fetches the nibble, then writes back the altered nibble in the following cycle, during which `busy` is high and any new request is dropped. Any access to the unpopulated bank 0 offsets F4h to FFh is harmless: it reads zero, stores nothing, and raises a one-cycle flag.

Top module: `nram_unit`

## Requirements
- R1: After synchronous reset, `bank_q`, `h_q`, `l_q`, `busy`, `rd_valid` and `unmapped` are all 0.
- R2: `bank_set` makes `bank_q` 1 and `bank_clr` makes it 0 from the next cycle. When both are high, set wins.
- R3: `h_load` and `l_load` store `h_din` and `l_din` in the pointer registers. The stored values appear on `h_q` and `l_q` from the next cycle.
- R4: Mode 0 (pointer pair) addresses {bank, high pointer, low pointer}.
- R5: Mode 1 (direct) addresses {bank, `req_opnd[7:0]`}.
- R6: Mode 2 (zero page) addresses {0, 0000b, `req_opnd[3:0]`}. The bank bit and `req_opnd[7:4]` have no effect.
- R7: A read accepted at a clock edge gives `rd_valid`=1 and `rd_data` at the next edge. A write is seen by every later read. `rd_valid` is 0 after all other cycles.
- R8: An access to addresses 0F4h to 0FFh reads 0 and stores nothing. It raises `unmapped` for exactly the one cycle after the request.
- R9: Op 3 sets and op 4 clears bit `req_bit` of the addressed nibble. The other three bits are kept. `busy` is 1 for exactly the cycle after the request, and the new value is stored by the end of that cycle.
- R10: A request presented while `busy` is 1 is dropped. It produces no read, no write, and no `unmapped` pulse.
- R11: `req_op` is coded as 0 none, 1 read, 2 write, 3 bit set, 4 bit clear; codes 5 to 7 do nothing. `req_mode` code 3 acts like direct mode.
- R12: A bank, high-pointer or low-pointer update in the same cycle as a request takes effect for later requests only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_set | input | 1 | Set the bank bit |
| bank_clr | input | 1 | Clear the bank bit |
| h_load | input | 1 | Load the high pointer |
| h_din | input | 4 | High pointer load value |
| l_load | input | 1 | Load the low pointer |
| l_din | input | 4 | Low pointer load value |
| bank_q | output | 1 | Current bank bit |
| h_q | output | 4 | High pointer read-back |
| l_q | output | 4 | Low pointer read-back |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_mode | input | 2 | Addressing mode |
| req_opnd | input | 8 | Direct or zero-page operand |
| req_bit | input | 2 | Bit index for set/clear |
| req_wdata | input | 4 | Write data |
| busy | output | 1 | Write-back cycle of a bit operation |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 4 | Read data |
| unmapped | output | 1 | Access hit the unpopulated bank 0 range |

## Verification
The hardest case to reach is a cycle where two things happen together: a bit operation is writing back, and a new request arrives that must be dropped. This is made worse when the bank bit or a pointer register changes in that same cycle. The random stimulus draws bit operations and, after many of them, drives a competing write into the busy cycle. Later reads must then show the original contents. The random stimulus also mixes bank and pointer updates into request cycles, so the old-value rule is checked against a reference model. Directed cases pin zero-page accesses with bank 1 selected, bit operations on the unpopulated range, and the reserved op and mode codes.

// File: rtl/nram_pkg.sv
package nram_pkg;

    localparam int NRAM_NIB_W = 4;
    localparam int NRAM_OFS_W = 8;
    localparam int NRAM_ZP_W  = 4;
    localparam int NRAM_B0_USED = 244;
    localparam int NRAM_BIT_W = $clog2(NRAM_NIB_W);

    typedef enum logic [1:0] {
        AM_PAIR = 2'd0,
        AM_DIR  = 2'd1,
        AM_ZP   = 2'd2,
        AM_RSV  = 2'd3
    } amode_e;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_BSET = 3'd3,
        OP_BCLR = 3'd4
    } op_e;

    function automatic logic [NRAM_NIB_W-1:0] nib_mask(input logic [NRAM_BIT_W-1:0] idx);
        logic [NRAM_NIB_W-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/nram_agen.sv
module nram_agen
    import nram_pkg::*;
#(
    parameter int NIB_W   = NRAM_NIB_W,
    parameter int OFS_W   = NRAM_OFS_W,
    parameter int ZP_W    = NRAM_ZP_W,
    parameter int B0_USED = NRAM_B0_USED,
    localparam int ADDR_W = OFS_W + 1
) (
    input  amode_e              mode,
    input  logic                bank,
    input  logic [NIB_W-1:0]    hptr,
    input  logic [NIB_W-1:0]    lptr,
    input  logic [OFS_W-1:0]    opnd,
    output logic [ADDR_W-1:0]   addr,
    output logic                unmapped
);

    always_comb begin
        case (mode)
            AM_PAIR: addr = {bank, hptr, lptr};
            AM_ZP:   addr = {{(ADDR_W-ZP_W){1'b0}}, opnd[ZP_W-1:0]};
            default: addr = {bank, opnd};
        endcase
    end

    assign unmapped = !addr[OFS_W] && (int'(addr[OFS_W-1:0]) >= B0_USED);

endmodule

// File: rtl/nram_array.sv
module nram_array
    import nram_pkg::*;
#(
    parameter int NIB_W   = NRAM_NIB_W,
    parameter int OFS_W   = NRAM_OFS_W,
    parameter int B0_USED = NRAM_B0_USED,
    localparam int ADDR_W = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [NIB_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [NIB_W-1:0]  rdata
);

    logic [1:0][NIB_W-1:0] bank_rd;
    logic                  rbank_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam int DEPTH = (b == 0) ? B0_USED : (1 << OFS_W);
        logic [NIB_W-1:0] mem [DEPTH];
        logic [NIB_W-1:0] rq;
        logic [OFS_W-1:0] w_ofs;
        logic [OFS_W-1:0] r_ofs;

        assign w_ofs = waddr[OFS_W-1:0];
        assign r_ofs = raddr[OFS_W-1:0];

        always_ff @(posedge clk) begin
            if (we && (waddr[OFS_W] == 1'(b)) && (int'(w_ofs) < DEPTH))
                mem[w_ofs] <= wdata;
            rq <= (int'(r_ofs) < DEPTH) ? mem[r_ofs] : '0;
        end

        assign bank_rd[b] = rq;
    end

    always_ff @(posedge clk) begin
        rbank_q <= raddr[OFS_W];
    end

    assign rdata = bank_rd[rbank_q];

    // R8
    wr_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (waddr[OFS_W] || (int'(waddr[OFS_W-1:0]) < B0_USED)));

endmodule

// File: rtl/nram_ctrl.sv
module nram_ctrl
    import nram_pkg::*;
#(
    parameter int NIB_W  = NRAM_NIB_W,
    parameter int ADDR_W = NRAM_OFS_W + 1,
    localparam int BIT_W = $clog2(NIB_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_unmapped,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic [NIB_W-1:0]  wdata_in,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [NIB_W-1:0]  mem_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic              unmapped
);

    typedef enum logic {ST_IDLE, ST_RMW} st_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BIT_W-1:0]  idx;
        logic              set;
        logic              mapped;
    } held_t;

    st_e   st_q;
    held_t held_q;
    op_e   op_c;
    logic  accept;
    logic  is_bit;
    logic  is_access;
    logic [NIB_W-1:0] mask;

    assign op_c      = op_e'(req_op);
    assign accept    = req_valid && (st_q == ST_IDLE);
    assign is_bit    = (op_c == OP_BSET) || (op_c == OP_BCLR);
    assign is_access = (op_c == OP_RD) || (op_c == OP_WR) || is_bit;
    assign mask      = nib_mask(held_q.idx);
    assign busy      = (st_q == ST_RMW);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            held_q   <= '0;
            rd_valid <= 1'b0;
            unmapped <= 1'b0;
        end else begin
            rd_valid <= accept && (op_c == OP_RD);
            unmapped <= accept && is_access && addr_unmapped;
            if (st_q == ST_IDLE) begin
                if (accept && is_bit) begin
                    st_q   <= ST_RMW;
                    held_q <= '{addr: addr, idx: bit_idx,
                                set: (op_c == OP_BSET), mapped: !addr_unmapped};
                end
            end else begin
                st_q <= ST_IDLE;
            end
        end
    end

    always_comb begin
        if (st_q == ST_RMW) begin
            mem_we    = held_q.mapped;
            mem_waddr = held_q.addr;
            mem_wdata = held_q.set ? (mem_rdata | mask) : (mem_rdata & ~mask);
        end else begin
            mem_we    = accept && (op_c == OP_WR) && !addr_unmapped;
            mem_waddr = addr;
            mem_wdata = wdata_in;
        end
    end

    // R9
    busy_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R9
    rmw_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (req_op == 3'd3 || req_op == 3'd4) && !addr_unmapped)
        |=> mem_we);

    // R7
    rdv_src_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(req_valid && (req_op == 3'd1) && !busy));

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!rd_valid && !unmapped));

endmodule

// File: rtl/nram_unit.sv
module nram_unit
    import nram_pkg::*;
#(
    parameter int NIB_W   = NRAM_NIB_W,
    parameter int OFS_W   = NRAM_OFS_W,
    parameter int ZP_W    = NRAM_ZP_W,
    parameter int B0_USED = NRAM_B0_USED,
    localparam int ADDR_W = OFS_W + 1,
    localparam int BIT_W  = $clog2(NIB_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bank_set,
    input  logic             bank_clr,
    input  logic             h_load,
    input  logic [NIB_W-1:0] h_din,
    input  logic             l_load,
    input  logic [NIB_W-1:0] l_din,
    output logic             bank_q,
    output logic [NIB_W-1:0] h_q,
    output logic [NIB_W-1:0] l_q,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [1:0]       req_mode,
    input  logic [OFS_W-1:0] req_opnd,
    input  logic [BIT_W-1:0] req_bit,
    input  logic [NIB_W-1:0] req_wdata,
    output logic             busy,
    output logic             rd_valid,
    output logic [NIB_W-1:0] rd_data,
    output logic             unmapped
);

    logic [ADDR_W-1:0] ag_addr;
    logic              ag_unmapped;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [NIB_W-1:0]  mem_wdata;
    logic [NIB_W-1:0]  mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= 1'b0;
            h_q    <= '0;
            l_q    <= '0;
        end else begin
            if (bank_set)      bank_q <= 1'b1;
            else if (bank_clr) bank_q <= 1'b0;
            if (h_load) h_q <= h_din;
            if (l_load) l_q <= l_din;
        end
    end

    nram_agen #(.NIB_W(NIB_W), .OFS_W(OFS_W), .ZP_W(ZP_W), .B0_USED(B0_USED)) agen_i (
        .mode     (amode_e'(req_mode)),
        .bank     (bank_q),
        .hptr     (h_q),
        .lptr     (l_q),
        .opnd     (req_opnd),
        .addr     (ag_addr),
        .unmapped (ag_unmapped)
    );

    nram_ctrl #(.NIB_W(NIB_W), .ADDR_W(ADDR_W)) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .addr          (ag_addr),
        .addr_unmapped (ag_unmapped),
        .bit_idx       (req_bit),
        .wdata_in      (req_wdata),
        .mem_rdata     (mem_rdata),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .mem_wdata     (mem_wdata),
        .busy          (busy),
        .rd_valid      (rd_valid),
        .unmapped      (unmapped)
    );

    nram_array #(.NIB_W(NIB_W), .OFS_W(OFS_W), .B0_USED(B0_USED)) array_i (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ag_addr),
        .rdata (mem_rdata)
    );

    assign rd_data = mem_rdata;

    // R6
    zp_bank0_chk: assert property (@(posedge clk) disable iff (rst)
        (req_mode == 2'd2) |-> (ag_addr[ADDR_W-1:ZP_W] == '0));

    // R2
    bank_set_chk: assert property (@(posedge clk) disable iff (rst)
        bank_set |=> bank_q);

    // R2
    bank_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bank_clr && !bank_set) |=> !bank_q);

    // R3
    h_load_chk: assert property (@(posedge clk) disable iff (rst)
        h_load |=> (h_q == $past(h_din)));

endmodule

// File: tb/nram_unit_tb.sv
module nram_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bank_set = 0, bank_clr = 0, h_load = 0, l_load = 0;
    logic [3:0] h_din = 0, l_din = 0;
    logic       bank_q;
    logic [3:0] h_q, l_q;
    logic       req_valid = 0;
    logic [2:0] req_op = 0;
    logic [1:0] req_mode = 0;
    logic [7:0] req_opnd = 0;
    logic [1:0] req_bit = 0;
    logic [3:0] req_wdata = 0;
    logic       busy, rd_valid, unmapped;
    logic [3:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] mdl [512];
    logic       m_bank = 0;
    logic [3:0] m_h = 0, m_l = 0;

    always #10 clk = ~clk;

    nram_unit dut_i (
        .clk(clk), .rst(rst), .bank_set(bank_set), .bank_clr(bank_clr),
        .h_load(h_load), .h_din(h_din), .l_load(l_load), .l_din(l_din),
        .bank_q(bank_q), .h_q(h_q), .l_q(l_q),
        .req_valid(req_valid), .req_op(req_op), .req_mode(req_mode),
        .req_opnd(req_opnd), .req_bit(req_bit), .req_wdata(req_wdata),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .unmapped(unmapped)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_addr(input logic [1:0] mode, input logic [7:0] opnd);
        case (mode)
            2'd0:    return {23'd0, m_bank, m_h, m_l};
            2'd2:    return {28'd0, opnd[3:0]};
            default: return {23'd0, m_bank, opnd};
        endcase
    endfunction

    function automatic bit is_unm(input int a);
        return (a < 256) && (a[7:0] >= 8'd244);
    endfunction

    function automatic string mode_tag(input logic [1:0] mode);
        case (mode)
            2'd0: return "R4";
            2'd2: return "R6";
            2'd3: return "R11";
            default: return "R5";
        endcase
    endfunction

    // One request plus optional same-cycle control updates (R12).
    // blk: drive a competing write into the busy cycle (R10).
    task automatic do_req(input logic [2:0] op, input logic [1:0] mode,
                          input logic [7:0] opnd, input logic [1:0] bi,
                          input logic [3:0] wd, input bit bs, input bit bc,
                          input bit hl, input logic [3:0] hd,
                          input bit ll, input logic [3:0] ld,
                          input bit blk, input logic [7:0] blk_opnd);
        int a;
        bit un;
        bit acc;
        a  = exp_addr(mode, opnd);
        un = is_unm(a);
        acc = (op >= 3'd1) && (op <= 3'd4);
        req_valid = 1; req_op = op; req_mode = mode; req_opnd = opnd;
        req_bit = bi; req_wdata = wd;
        bank_set = bs; bank_clr = bc; h_load = hl; h_din = hd; l_load = ll; l_din = ld;
        @(negedge clk);
        req_valid = 0; bank_set = 0; bank_clr = 0; h_load = 0; l_load = 0;
        if (bs) m_bank = 1'b1; else if (bc) m_bank = 1'b0;
        if (hl) m_h = hd;
        if (ll) m_l = ld;
        chk("R2 bank_q", int'(bank_q), int'(m_bank));
        chk("R3 h_q", int'(h_q), int'(m_h));
        chk("R3 l_q", int'(l_q), int'(m_l));
        chk("R8 unmapped", int'(unmapped), int'(acc && un));
        chk("R7 rd_valid", int'(rd_valid), int'(op == 3'd1));
        if (op == 3'd1)
            chk({mode_tag(mode), " R7 R8 rd_data"}, int'(rd_data), un ? 0 : int'(mdl[a]));
        if (op == 3'd2 && !un) mdl[a] = wd;
        if (op == 3'd3 || op == 3'd4) begin
            chk("R9 busy high", int'(busy), 1);
            if (blk) begin
                req_valid = 1; req_op = 3'd2; req_mode = 2'd1; req_opnd = blk_opnd;
                req_wdata = ~mdl[{23'd0, m_bank, blk_opnd}];
            end
            @(negedge clk);
            req_valid = 0;
            chk("R9 busy low", int'(busy), 0);
            chk("R10 no unmapped", int'(unmapped), 0);
            chk("R10 no rd_valid", int'(rd_valid), 0);
            if (!un) begin
                if (op == 3'd3) mdl[a][bi] = 1'b1;
                else            mdl[a][bi] = 1'b0;
            end
        end else begin
            chk("R11 busy idle", int'(busy), 0);
        end
    endtask

    task automatic rd_chk(input logic [1:0] mode, input logic [7:0] opnd);
        do_req(3'd1, mode, opnd, 2'd0, 4'd0, 0, 0, 0, 4'd0, 0, 4'd0, 0, 8'd0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        repeat (198000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 512; i++) mdl[i] = 4'd0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 bank_q", int'(bank_q), 0);
        chk("R1 h_q", int'(h_q), 0);
        chk("R1 l_q", int'(l_q), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 unmapped", int'(unmapped), 0);

        // Fill both banks with direct writes (unmapped ones flagged, R8)
        for (int b = 0; b < 2; b++) begin
            for (int o = 0; o < 256; o++)
                do_req(3'd2, 2'd1, 8'(o), 2'd0, 4'($urandom), b == 1, 0, 0, 4'd0, 0, 4'd0, 0, 8'd0);
        end

        // R6: zero page with bank 1 selected and high operand bits set
        do_req(3'd2, 2'd2, 8'hA7, 2'd0, 4'h9, 0, 0, 0, 4'd0, 0, 4'd0, 0, 8'd0);
        rd_chk(2'd2, 8'h57);
        do_req(3'd1, 2'd1, 8'h07, 2'd0, 4'd0, 0, 1, 0, 4'd0, 0, 4'd0, 0, 8'd0);
        rd_chk(2'd1, 8'h07);

        // R2: set and clear together, set wins
        do_req(3'd0, 2'd0, 8'd0, 2'd0, 4'd0, 1, 1, 0, 4'd0, 0, 4'd0, 0, 8'd0);

        // R8: unmapped read, write, bit op in bank 0
        do_req(3'd0, 2'd0, 8'd0, 2'd0, 4'd0, 0, 1, 1, 4'hF, 1, 4'h5, 0, 8'd0);
        do_req(3'd2, 2'd0, 8'd0, 2'd0, 4'hE, 0, 0, 0, 4'd0, 0, 4'd0, 0, 8'd0);
        rd_chk(2'd0, 8'd0);
        do_req(3'd3, 2'd1, 8'hF9, 2'd2, 4'd0, 0, 0, 0, 4'd0, 0, 4'd0, 0, 8'd0);
        rd_chk(2'd1, 8'hF9);

        // R10: write blocked during busy, then read the victim
        do_req(3'd4, 2'd1, 8'h10, 2'd1, 4'd0, 0, 0, 0, 4'd0, 0, 4'd0, 1, 8'h22);
        rd_chk(2'd1, 8'h22);
        rd_chk(2'd1, 8'h10);

        // R11: codes 5..7 do nothing; mode 3 acts like direct
        for (int c = 5; c < 8; c++)
            do_req(3'(c), 2'd1, 8'h30, 2'd0, ~mdl[8'h30], 0, 0, 0, 4'd0, 0, 4'd0, 0, 8'd0);
        rd_chk(2'd3, 8'h30);

        // R12: pointer and bank change in the request cycle use old values
        do_req(3'd1, 2'd0, 8'd0, 2'd0, 4'd0, 1, 0, 1, 4'h3, 1, 4'hC, 0, 8'd0);
        rd_chk(2'd0, 8'd0);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] op;
            int r;
            r = $urandom_range(0, 9);
            op = (r < 4) ? 3'd1 : (r < 6) ? 3'd2 : (r < 8) ? 3'($urandom_range(3, 4)) : 3'($urandom_range(0, 7));
            do_req(op, 2'($urandom), 8'($urandom), 2'($urandom), 4'($urandom),
                   ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                   ($urandom_range(0, 3) == 0), 4'($urandom),
                   ($urandom_range(0, 3) == 0), 4'($urandom),
                   ($urandom_range(0, 2) == 0), 8'($urandom));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule